// File: doc/BRIEF.md
# Link Error Counter With Threshold Cause

This block keeps a running count of link-layer error pulses and compares it against a software-programmed limit. The count and the limit live together in one 32-bit word. The low half is the count and the high half is the limit. Software writes the word with byte enables and reads it back whole. When an error pulse moves the count onto or past a non-zero limit, the block raises a pending cause flag. That flag feeds an interrupt status register, which can dismiss it with a clear strobe.

A write that touches any byte of the count half zeroes the count and drops the pending cause, whatever the data. A write that touches only the limit bytes leaves the count alone. A limit of zero switches the cause off. Several instances of the same design can serve different error sources, such as symbol decode, CRC and handshake errors.

Top module: `link_err_counter`

## Requirements
- R1: After a synchronous active-low reset the word reads 0x00000000 and the cause flag is low.
- R2: The read word carries the error count in bits [15:0] and the limit in bits [31:16]. Writes update limit bytes 2 and 3 only where wr_be[2] or wr_be[3] is set.
- R3: Each error pulse that is not discarded raises the count by exactly one, visible after the next clock edge.
- R4: The count saturates at 0xFFFF. Further pulses leave it at 0xFFFF.
- R5: A write with wr_be[0] or wr_be[1] set zeroes the count whatever the data. An error pulse in the same cycle is discarded, and the count reads zero afterwards.
- R6: A write whose wr_be[1:0] is 00 leaves the count unchanged (apart from a same-cycle error pulse).
- R7: The cause flag rises when an accepted error pulse arrives while the limit is non-zero and the incremented (saturated) count is greater than or equal to the limit. The comparison uses the limit held before that edge. Changing the limit alone never sets the flag.
- R8: While the limit is zero the flag never rises. A write that leaves the limit at zero clears a pending flag.
- R9: A count-reset write (R5) clears the pending flag, and this takes precedence over any setting event in the same cycle.
- R10: A cause_clr strobe clears the pending flag. A setting event in the same cycle wins over the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pulse | input | 1 | One-cycle error event from the link layer |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write; bytes 0-1 count, 2-3 limit |
| wr_data | input | 32 | Write data |
| cause_clr | input | 1 | Write-one-to-clear strobe from the interrupt status register |
| rd_data | output | 32 | Current word: limit in [31:16], count in [15:0] |
| cause_flag | output | 1 | Pending threshold cause |

## Verification
The assertions assume that err_pulse, wr_en and cause_clr are sampled only at the clock edge and may be high in any combination. They assume nothing about pulse spacing. Count-reset writes, limit-only writes, clear strobes and error pulses are therefore drawn independently in the random phase, so that collisions happen often. Limits are kept small so that the cause fires many times between resets. A directed run of more than 65,535 pulses drives the count into saturation, and further directed steps place a setting event in the same cycle as each kind of clear.

// File: rtl/errcnt_pkg.sv
// errcnt_pkg: shared constants for the link error counter.
// Assumes the count and limit halves have equal width, a whole number of bytes.
package errcnt_pkg;
    localparam int unsigned HALF_W_DEF = 16;
    localparam int unsigned BYTE_W     = 8;

    // Number of bytes in one half of the word.
    function automatic int unsigned half_bytes(input int unsigned half_w);
        return half_w / BYTE_W;
    endfunction
endpackage

// File: rtl/errcnt_count.sv
// errcnt_count: saturating error counter with a synchronous zeroing input.
// Assumes zap wins over err in the same cycle; err is a one-cycle event.
module errcnt_count #(
    parameter int unsigned CNT_W = errcnt_pkg::HALF_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zap,
    input  logic             err,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             accepted
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Pulse survives unless a count reset shares its cycle.
    assign accepted = err && !zap;
    // Value the count would take after one more error, saturated.
    assign cnt_inc  = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;

    // Count register: zero on reset or zap, otherwise step on accepted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (zap)      cnt <= '0;
        else if (accepted) cnt <= cnt_inc;
    end

    AST_ZAP_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        zap |=> (cnt == '0)); // R5
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !zap) |=> (cnt == CNT_MAX)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!zap && $past(rst_n)) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R3
endmodule

// File: rtl/errcnt_limit.sv
// errcnt_limit: byte-enabled limit register for the upper half of the word.
// Assumes be and data are only meaningful when we is high.
module errcnt_limit #(
    parameter int unsigned LIM_W = errcnt_pkg::HALF_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LIM_W/8-1:0] be,
    input  logic [LIM_W-1:0] data,
    output logic [LIM_W-1:0] lim,
    output logic [LIM_W-1:0] lim_next
);
    localparam int unsigned NBYTES = errcnt_pkg::half_bytes(LIM_W);

    // Per-byte merge of write data into the held limit.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign lim_next[b*8 +: 8] = (we && be[b]) ? data[b*8 +: 8] : lim[b*8 +: 8];
    end

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n) lim <= '0;
        else        lim <= lim_next;
    end

    AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(lim)); // R2
endmodule

// File: rtl/errcnt_cause.sv
// errcnt_cause: pending threshold cause with its set and clear priorities.
// Assumes cnt_inc is the saturated post-increment count of the paired counter.
module errcnt_cause #(
    parameter int unsigned W = errcnt_pkg::HALF_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accepted,
    input  logic [W-1:0] cnt_inc,
    input  logic [W-1:0] lim,
    input  logic [W-1:0] lim_next,
    input  logic         zap,
    input  logic         clr,
    output logic         pend
);
    logic hit;

    // Setting event: accepted error reaching a non-zero limit.
    assign hit = accepted && (lim != '0) && (cnt_inc >= lim);

    // Pending flag: zap and zero limit dominate, then set, then clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend <= 1'b0;
        else if (zap || lim_next == '0)      pend <= 1'b0;
        else if (hit)                        pend <= 1'b1;
        else if (clr)                        pend <= 1'b0;
    end

    AST_PEND_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (lim != '0)); // R8
    AST_ZAP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        zap |=> !pend); // R9
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(accepted)); // R7
endmodule

// File: rtl/link_err_counter.sv
// link_err_counter: one-word error counter with a limit and threshold cause.
// Assumes a 32-bit word split into two 16-bit halves by default; the
// count half is bytes 0..HB-1 and the limit half the bytes above it.
module link_err_counter #(
    parameter int unsigned HALF_W = errcnt_pkg::HALF_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  err_pulse,
    input  logic                  wr_en,
    input  logic [HALF_W/4-1:0]   wr_be,
    input  logic [2*HALF_W-1:0]   wr_data,
    input  logic                  cause_clr,
    output logic [2*HALF_W-1:0]   rd_data,
    output logic                  cause_flag
);
    localparam int unsigned HB = errcnt_pkg::half_bytes(HALF_W);

    logic              zap;
    logic              accepted;
    logic [HALF_W-1:0] cnt, cnt_inc, lim, lim_next;

    // A write to any count byte resets the count and the cause.
    assign zap = wr_en && (|wr_be[HB-1:0]);

    errcnt_count #(.CNT_W(HALF_W)) u_count (
        .clk(clk), .rst_n(rst_n), .zap(zap), .err(err_pulse),
        .cnt(cnt), .cnt_inc(cnt_inc), .accepted(accepted)
    );

    errcnt_limit #(.LIM_W(HALF_W)) u_limit (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .be(wr_be[2*HB-1:HB]),
        .data(wr_data[2*HALF_W-1:HALF_W]), .lim(lim), .lim_next(lim_next)
    );

    errcnt_cause #(.W(HALF_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .accepted(accepted), .cnt_inc(cnt_inc),
        .lim(lim), .lim_next(lim_next), .zap(zap), .clr(cause_clr),
        .pend(cause_flag)
    );

    assign rd_data = {lim, cnt};

    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_clr && !err_pulse) |=> !cause_flag); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !cause_flag)); // R1
endmodule

// File: tb/link_err_counter_test.sv
module link_err_counter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        err_pulse, wr_en, cause_clr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        cause_flag;

    int unsigned n_vec = 0, n_bad = 0;
    bit          done = 0;

    // Reference state
    logic [15:0] m_cnt, m_lim;
    logic        m_pend;

    link_err_counter uut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .cause_clr(cause_clr),
        .rd_data(rd_data), .cause_flag(cause_flag)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] sat_inc(input logic [15:0] v);
        return (v == 16'hFFFF) ? v : v + 16'd1;
    endfunction

    // Next reference state from the requirements
    task automatic model_step();
        logic        zap, acc, hit;
        logic [15:0] nl;
        zap = wr_en && (wr_be[0] || wr_be[1]);
        acc = err_pulse && !zap;
        nl[7:0]  = (wr_en && wr_be[2]) ? wr_data[23:16] : m_lim[7:0];
        nl[15:8] = (wr_en && wr_be[3]) ? wr_data[31:24] : m_lim[15:8];
        hit = acc && m_lim != 0 && sat_inc(m_cnt) >= m_lim;
        if (zap || nl == 0) m_pend = 1'b0;
        else if (hit)       m_pend = 1'b1;
        else if (cause_clr) m_pend = 1'b0;
        if (zap)      m_cnt = 16'd0;
        else if (acc) m_cnt = sat_inc(m_cnt);
        m_lim = nl;
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (rd_data !== {m_lim, m_cnt} || cause_flag !== m_pend) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h flag=%b expected rd_data=%h flag=%b",
                     tag, rd_data, cause_flag, {m_lim, m_cnt}, m_pend);
        end
    endtask

    // Drive at negedge, clock, then check at the following negedge.
    task automatic apply(input logic e, input logic w, input logic [3:0] be,
                         input logic [31:0] d, input logic c, input string tag);
        err_pulse = e; wr_en = w; wr_be = be; wr_data = d; cause_clr = c;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_inputs();
        err_pulse = 0; wr_en = 0; wr_be = 0; wr_data = 0; cause_clr = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        idle_inputs();
        rst_n = 0;
        m_cnt = 0; m_lim = 0; m_pend = 0;
        @(negedge clk); @(negedge clk);
        compare("R1 reset state");
        rst_n = 1;

        // R3 counting with limit zero, R8 no cause
        for (int i = 0; i < 5; i++) apply(1, 0, 4'h0, 0, 0, "R3 count / R8 zero limit");
        // R6 limit-only write keeps the count, R2 layout
        apply(0, 1, 4'b1100, 32'h0008_ABCD, 0, "R6 limit-only write / R2");
        apply(1, 1, 4'b0100, 32'h0007_0000, 0, "R2 byte enable / R6");
        // R7 reach limit 7 with a pulse
        apply(1, 0, 4'h0, 0, 0, "R7 reach limit");
        // R10 clear and set together: set wins
        apply(1, 0, 4'h0, 0, 1, "R10 set beats clear");
        apply(0, 0, 4'h0, 0, 1, "R10 clear strobe");
        // R7 limit change alone does not set
        apply(0, 1, 4'b1100, 32'h0003_0000, 0, "R7 limit change alone");
        apply(1, 0, 4'h0, 0, 0, "R7 above limit");
        // R8 write zero limit drops pending
        apply(0, 1, 4'b1100, 32'h0000_0000, 0, "R8 zero limit clears");
        apply(1, 0, 4'h0, 0, 0, "R8 no set at zero limit");
        // R5/R9 count-reset with pulse and pending
        apply(0, 1, 4'b1100, 32'h0001_0000, 0, "R2 set limit 1");
        apply(1, 0, 4'h0, 0, 0, "R7 set at limit 1");
        apply(1, 1, 4'b0001, 32'hFFFF_1234, 0, "R5 pulse discarded / R9");
        apply(1, 1, 4'b0010, 32'h0000_0000, 0, "R9 zap beats set");

        // R4 saturation with limit 0xFFFF
        apply(0, 1, 4'b1111, 32'hFFFF_0000, 0, "R2 set limit FFFF");
        for (int i = 0; i < 65534; i++) begin
            err_pulse = 1; wr_en = 0; wr_be = 0; cause_clr = 0;
            model_step();
            @(negedge clk);
        end
        compare("R3 count near top");
        apply(1, 0, 4'h0, 0, 0, "R4 reach FFFF / R7");
        apply(0, 0, 4'h0, 0, 1, "R10 clear at top");
        apply(1, 0, 4'h0, 0, 0, "R4 saturate / R7 saturated pulse");
        apply(1, 0, 4'h0, 0, 0, "R4 saturate hold");
        apply(0, 1, 4'b0011, 0, 0, "R5 reset count from top");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic        e, w, c;
            logic [3:0]  be;
            logic [31:0] d;
            e  = ($urandom % 3) == 0;
            w  = ($urandom % 25) == 0;
            c  = ($urandom % 9) == 0;
            be = 4'($urandom);
            d  = {16'($urandom % 20), 16'($urandom)};
            apply(e, w, be, d, c, "R3 R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule